// File: doc/BRIEF.md
# Two-Segment Coarse/Fine Time-to-Digital Converter

This block measures, for one pixel, the interval between a start event and the first photon detection (stop). A coarse segment counts cycles of the TDC clock so that the range covers many periods. A fine segment captures a bus of evenly spaced phase copies of that clock at the stop edge and decodes where inside the current cycle the stop arrived. The two parts are joined into one timestamp in units of the fine step.

Counters run on both clock edges, so there are two coarse values. The fine code picks the one that was not changing when the stop arrived, which removes the off-by-one error at the boundary between the segments. The phase snapshot passes through a three-neighbour majority filter before the transition is located, so a single wrong bit does not move the code. The stop is handled in its own domain. A toggle handshake with two synchronising flops brings the result back to the clock domain, and a one-cycle valid pulse follows two clock edges after the stop. If no stop arrives before the coarse counter would wrap, the block closes the window with an overflow result.

Top module: `tdc_two_seg`

## Requirements
- R1: After a synchronous reset, `valid` and `ovf` are 0 and `coarse`, `fine` and `stamp` are 0.
- R2: `coarse` equals n, where the stop arrives in the clock cycle that begins at the n-th rising edge after the rising edge that sampled `start` high (n = 0 for the sampling cycle itself), for n from 0 to 255.
- R3: `phase[k]` carries the TDC clock delayed by k/16 of a period. `fine` is the index k for which `phase[k]` is 1 and `phase[(k+1) mod 16]` is 0, which is the 1/16-period slot of the cycle that holds the stop.
- R4: Flipping one bit of the captured phase pattern that is at least two positions away from both transitions leaves `fine` unchanged.
- R5: The coarse value comes from the falling-edge counter when `fine` is 0 to 7 and from the rising-edge counter when `fine` is 8 to 15. `coarse` is correct in both halves of a cycle, including the first and last slot.
- R6: `stamp` equals `coarse` * 16 + `fine`, that is `{coarse, fine}`.
- R7: `valid` is a one-cycle pulse. It is low after the first rising edge that follows the stop and high after the second.
- R8: Only the first stop after `start` is measured. Later stops raise no `valid` and leave `coarse`, `fine` and `stamp` unchanged until reset.
- R9: `start` is accepted only while idle after reset. A `start` during a measurement does not restart the count.
- R10: If no stop has arrived by the 256th rising edge after `start` was sampled, `valid` pulses after that edge with `ovf` = 1, `coarse` = 255, `fine` = 15 and `stamp` = 4095. Stops after that are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDC clock |
| rst | input | 1 | Synchronous active-high reset (also clears the stop-domain toggle) |
| phase | input | NPH | Phase copies of the TDC clock, bit k delayed by k/NPH period |
| start | input | 1 | Start of the measurement window, sampled on the rising edge |
| stop | input | 1 | Photon detection, asynchronous, its rising edge is measured |
| coarse | output | CW | Selected coarse cycle count |
| fine | output | log2(NPH) | Fine slot inside the cycle |
| stamp | output | CW+log2(NPH) | Combined timestamp `{coarse, fine}` |
| valid | output | 1 | One-cycle result strobe |
| ovf | output | 1 | Window ended without a stop |

## Verification
The hardest case to reach is a stop placed in a chosen sub-cycle slot, so that each of the two coarse counters is selected, together with a phase snapshot that agrees with that slot. The bench does this by timing the stop rise at a fraction of a period after a known rising edge. Just before that rise it drives the phase bus with the pattern that slot implies, sometimes with one bit flipped. Corner cases include the first and last slot, cycle 255 just before the counter wraps, and a window left to expire.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tdc_state_t;
endpackage

// File: rtl/tdc_fine_enc.sv
// Bubble-tolerant fine encoder: circular 3-input majority filter, then the
// lowest index whose filtered bit is 1 and whose successor is 0 (R3, R4).
module tdc_fine_enc #(
  parameter int NPH = 16,
  parameter int FW  = $clog2(NPH)
) (
  input  logic [NPH-1:0] snap,
  output logic [FW-1:0]  code
);
  logic [NPH-1:0] filt;
  logic [NPH-1:0] edg;

  for (genvar k = 0; k < NPH; k++) begin : g_filt
    localparam int KP = (k + NPH - 1) % NPH;
    localparam int KN = (k + 1) % NPH;
    assign filt[k] = (snap[KP] & snap[k]) | (snap[k] & snap[KN]) | (snap[KP] & snap[KN]);
  end

  for (genvar k = 0; k < NPH; k++) begin : g_edge
    assign edg[k] = filt[k] & ~filt[(k + 1) % NPH];
  end

  always_comb begin
    logic found;
    found = 1'b0;
    code  = '0;
    for (int k = 0; k < NPH; k++) begin
      if (edg[k] && !found) begin
        code  = FW'(k);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdc_coarse_pair.sv
// Two coarse counters: one on rising, one on falling TDC clock edges (R2, R5).
module tdc_coarse_pair #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic [CW-1:0] cnt_r,
  output logic [CW-1:0] cnt_f
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt_r <= '0;
    else             cnt_r <= cnt_r + 1'b1;
  end

  always_ff @(negedge clk) begin
    if (rst || !run) cnt_f <= '0;
    else             cnt_f <= cnt_f + 1'b1;
  end

  // R2: while measuring, the rising-edge counter steps by one each cycle
  a_r2_coarse_advances: assert property (@(posedge clk) disable iff (rst)
    run |=> (cnt_r == $past(cnt_r) + 1'b1));
endmodule

// File: rtl/tdc_hit_capture.sv
// Stop-domain snapshot with toggle handshake and two-flop synchroniser (R7, R8).
module tdc_hit_capture #(
  parameter int NPH = 16,
  parameter int CW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stop,
  input  logic           run,
  input  logic [NPH-1:0] phase,
  input  logic [CW-1:0]  cnt_r,
  input  logic [CW-1:0]  cnt_f,
  output logic [NPH-1:0] snap_ph,
  output logic [CW-1:0]  snap_r,
  output logic [CW-1:0]  snap_f,
  output logic           hit_evt,
  output logic           pending
);
  logic tag;
  logic sync1, sync2;

  // The gate closes as soon as one stop is taken (tag != sync2), so only the first stop counts.
  always_ff @(posedge stop or posedge rst) begin
    if (rst) begin
      tag     <= 1'b0;
      snap_ph <= '0;
      snap_r  <= '0;
      snap_f  <= '0;
    end else if (run && (tag == sync2)) begin
      tag     <= ~tag;
      snap_ph <= phase;
      snap_r  <= cnt_r;
      snap_f  <= cnt_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= tag;
      sync2 <= sync1;
    end
  end

  assign hit_evt = sync1 ^ sync2;
  assign pending = tag ^ sync2;
endmodule

// File: rtl/tdc_two_seg.sv
module tdc_two_seg
  import tdc_pkg::*;
#(
  parameter int NPH = 16,
  parameter int CW  = 8,
  localparam int FW = $clog2(NPH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPH-1:0]   phase,
  input  logic             start,
  input  logic             stop,
  output logic [CW-1:0]    coarse,
  output logic [FW-1:0]    fine,
  output logic [CW+FW-1:0] stamp,
  output logic             valid,
  output logic             ovf
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam int            HALF = NPH / 2;

  tdc_state_t     st;
  logic           run;
  logic [CW-1:0]  cnt_r, cnt_f, snap_r, snap_f, sel;
  logic [NPH-1:0] snap_ph;
  logic [FW-1:0]  code;
  logic           hit_evt, pending;

  assign run = (st == ST_RUN);

  tdc_coarse_pair #(.CW(CW)) u_coarse (
    .clk(clk), .rst(rst), .run(run), .cnt_r(cnt_r), .cnt_f(cnt_f)
  );

  tdc_hit_capture #(.NPH(NPH), .CW(CW)) u_cap (
    .clk(clk), .rst(rst), .stop(stop), .run(run), .phase(phase),
    .cnt_r(cnt_r), .cnt_f(cnt_f), .snap_ph(snap_ph), .snap_r(snap_r),
    .snap_f(snap_f), .hit_evt(hit_evt), .pending(pending)
  );

  tdc_fine_enc #(.NPH(NPH), .FW(FW)) u_enc (
    .snap(snap_ph), .code(code)
  );

  // R5: early half of the cycle -> falling-edge counter, late half -> rising-edge counter
  assign sel = (int'(code) < HALF) ? snap_f : snap_r;

  // R1, R7..R10: window control and registered results
  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      valid  <= 1'b0;
      ovf    <= 1'b0;
      coarse <= '0;
      fine   <= '0;
    end else begin
      valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) st <= ST_RUN;
        ST_RUN: begin
          if (hit_evt) begin
            st     <= ST_DONE;
            valid  <= 1'b1;
            coarse <= sel;
            fine   <= code;
          end else if (cnt_r == CMAX && !pending) begin
            st     <= ST_DONE;
            valid  <= 1'b1;
            ovf    <= 1'b1;
            coarse <= CMAX;
            fine   <= '1;
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign stamp = {coarse, fine}; // R6

  a_r7_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  a_r8_valid_only_on_close: assert property (@(posedge clk) disable iff (rst)
    valid |-> (st == ST_DONE));
  a_r10_ovf_with_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> valid);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |=> (st != ST_IDLE));
endmodule

// File: tb/tdc_two_seg_tb.sv
`timescale 1ns/1ps
module tdc_two_seg_tb_top;
  localparam int NPH = 16;
  localparam int CW  = 8;
  localparam int FW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPH-1:0] phase = '0;
  logic start = 1'b0;
  logic stop  = 1'b0;
  logic [CW-1:0] coarse;
  logic [FW-1:0] fine;
  logic [CW+FW-1:0] stamp;
  logic valid, ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tdc_two_seg #(.NPH(NPH), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .phase(phase), .start(start), .stop(stop),
    .coarse(coarse), .fine(fine), .stamp(stamp), .valid(valid), .ovf(ovf)
  );

  // Vectors: {cycle n, fine slot f, bubble mode: 0 none, 1 in low run, 2 in high run}
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{0, 0, 0}, '{0, 9, 0}, '{5, 7, 0}, '{5, 8, 0}, '{37, 15, 1},
    '{100, 3, 2}, '{255, 2, 0}, '{255, 12, 1}, '{64, 0, 2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [NPH-1:0] pat(input int f, input int bub);
    logic [NPH-1:0] p;
    for (int k = 0; k < NPH; k++) p[k] = (((f - k + NPH) % NPH) < NPH / 2);
    if (bub == 1) p[(f + 4) % NPH] = ~p[(f + 4) % NPH];
    if (bub == 2) p[(f - 3 + NPH) % NPH] = ~p[(f - 3 + NPH) % NPH];
    return p;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    start = 1'b0;
    stop  = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // Returns right at the rising edge that samples start (E0).
  task automatic do_start();
    @(negedge clk) start = 1'b1;
    @(posedge clk);
  endtask

  // Called at a rising edge; places the stop in slot f of that cycle.
  task automatic stop_in_slot(input int f, input int bub);
    #0.05 start = 1'b0;
    phase = pat(f, bub);
    #(0.1 + f * 0.3125) stop = 1'b1;
  endtask

  task automatic measure(input int n, input int f, input int bub);
    do_reset();
    do_start();
    repeat (n) @(posedge clk);
    stop_in_slot(f, bub);
    @(posedge clk);
    #1 stop = 1'b0;
    chk(valid == 1'b0, "R7 valid early", valid, 0);
    @(posedge clk);
    #1;
    chk(valid == 1'b1, "R7 valid", valid, 1);
    chk(coarse == CW'(n), (f < 8) ? "R2/R5 coarse falling-counter half" : "R2/R5 coarse rising-counter half", coarse, n);
    chk(fine == FW'(f), (bub != 0) ? "R4 fine with bubble" : "R3 fine", fine, f);
    chk(stamp == (CW+FW)'(n * 16 + f), "R6 stamp", stamp, n * 16 + f);
    chk(ovf == 1'b0, "R10 no ovf", ovf, 0);
    @(posedge clk);
    #1 chk(valid == 1'b0, "R7 one-cycle pulse", valid, 0);
  endtask

  initial begin
    do_reset();
    #1;
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(ovf == 1'b0, "R1 ovf", ovf, 0);
    chk(coarse == '0 && fine == '0, "R1 coarse/fine", {coarse, fine}, 0);
    chk(stamp == '0, "R1 stamp", stamp, 0);

    for (int i = 0; i < NV; i++) measure(VEC[i][0], VEC[i][1], VEC[i][2]);

    // R8: a second stop after a result is ignored
    @(posedge clk);
    stop_in_slot(11, 0);
    repeat (3) begin
      @(posedge clk);
      #1 stop = 1'b0;
      chk(valid == 1'b0, "R8 second stop no valid", valid, 0);
    end
    chk(stamp == 12'(64 * 16), "R8 outputs held", stamp, 64 * 16);

    // R9: start during a measurement does not restart the count
    do_reset();
    do_start();
    repeat (3) @(posedge clk);
    #1 start = 1'b1;
    repeat (7) @(posedge clk);
    stop_in_slot(5, 0);
    repeat (2) @(posedge clk);
    #1 stop = 1'b0;
    chk(valid == 1'b1, "R9 valid", valid, 1);
    chk(coarse == 8'd10, "R9 coarse not restarted", coarse, 10);

    // R10: window expires without a stop
    do_reset();
    do_start();
    #1 start = 1'b0;
    repeat (255) @(posedge clk);
    #1 chk(valid == 1'b0, "R10 no early close", valid, 0);
    @(posedge clk);
    #1;
    chk(valid == 1'b1, "R10 valid", valid, 1);
    chk(ovf == 1'b1, "R10 ovf", ovf, 1);
    chk(stamp == 12'hFFF, "R10 stamp saturated", stamp, 4095);
    @(posedge clk);
    stop_in_slot(6, 0);
    repeat (3) begin
      @(posedge clk);
      #1 stop = 1'b0;
      chk(valid == 1'b0, "R10 stop after overflow ignored", valid, 0);
    end
    chk(stamp == 12'hFFF && ovf, "R10 outputs held", stamp, 4095);

    do_reset();
    #1 chk(ovf == 1'b0 && valid == 1'b0, "R1 reset after overflow", ovf, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule